// File: doc/BRIEF.md
# Receive FIFO Pause Watermark Controller

This block watches how full the receive FIFO is and tells the transmit side when to send flow-control PAUSE frames. If the fill level reaches a programmable high mark, it raises a one-cycle request that carries the configured pause time in quanta. While the link partner is held off, it repeats that request every half pause time. When the fill level drops below a programmable low mark, it raises one request with zero quanta, which acts as a resume, and then goes back to idle. Building and sending the frame itself is handled elsewhere.

Both marks are given in units of 8 bytes. A high mark of zero turns pause generation off. A second path handles PAUSE frames received from the link partner. When honouring is enabled, such a frame holds the local transmitter off for the quanta it carries. One quantum is `QUANTUM_CYC` clock cycles.

Top module: `rxpause_wm_ctrl`

## Requirements
- R1: After reset, `pause_req` and `tx_halt` are low and the controller is idle.
- R2: The mark fields count 8-byte units. A pause is requested when `fill_bytes >= 8*hi_mark`, and is not requested at `8*hi_mark - 1`.
- R3: A pause request is a one-cycle pulse on `pause_req`, with `pause_req_quanta` equal to `pause_quanta_cfg`. It appears in the cycle after the level is seen. It does not repeat just because the level stays high.
- R4: While idle, no request is raised if `hi_mark` is zero or `tx_pause_en` is low, whatever the fill level.
- R5: While paused, the request is reissued with `pause_quanta_cfg` every `max(pause_quanta_cfg>>1,1)*QUANTUM_CYC + 1` cycles, as long as the level has not dropped below the low mark.
- R6: While paused, a level below `8*lo_mark` gives exactly one pulse with `pause_req_quanta` = 0 and returns the controller to idle. A level equal to `8*lo_mark` does not resume.
- R7: While paused, dropping `tx_pause_en` or writing `hi_mark` to zero gives one zero-quanta resume pulse and returns the controller to idle.
- R8: With `rx_honor_en` high, a `rx_pause_seen` pulse makes `tx_halt` high from the next cycle for `rx_pause_time*QUANTUM_CYC` cycles. A new frame reloads the time, and a frame with zero quanta clears the halt at the next edge.
- R9: With `rx_honor_en` low, received frames are ignored and `tx_halt` is low from the next edge, even if a halt was running.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| fill_bytes | input | LVL_W | Receive FIFO occupancy in bytes |
| hi_mark | input | WM_W | High watermark, 8-byte units, 0 disables |
| lo_mark | input | WM_W | Low watermark, 8-byte units |
| pause_quanta_cfg | input | QT_W | Pause time to advertise, in quanta |
| tx_pause_en | input | 1 | Enables pause generation |
| rx_honor_en | input | 1 | Enables halting on received PAUSE frames |
| rx_pause_seen | input | 1 | One-cycle pulse: a PAUSE frame was received |
| rx_pause_time | input | QT_W | Quanta carried by the received frame |
| pause_req | output | 1 | One-cycle request to send a PAUSE frame |
| pause_req_quanta | output | QT_W | Quanta for the requested frame, 0 means resume |
| tx_halt | output | 1 | Holds the local transmitter off |

## Verification
The assertions assume the programming is sensible: `hi_mark` is above `lo_mark`, and the mark and pause-time inputs hold steady while a request is being formed. The checks on request quanta compare against the pause time sampled one edge earlier, which is only meaningful if that value is not changing. The stimulus changes the configuration only while the controller is idle, or one cycle before the check that depends on it. The fill level is stepped across each mark and back, one step per cycle, which brings out the exact boundaries at 8 times the mark and at that value minus one.

// File: rtl/rxpause_pkg.sv
package rxpause_pkg;

    typedef enum logic {
        FC_IDLE   = 1'b0,
        FC_PAUSED = 1'b1
    } fc_state_e;

endpackage

// File: rtl/rxpause_quanta_tick.sv
module rxpause_quanta_tick #(
    parameter int CYC = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    output logic tick
);
    localparam int CW = (CYC > 1) ? $clog2(CYC) : 1;

    generate
        if (CYC > 1) begin : g_div
            logic [CW-1:0] cnt_d, cnt_q;

            assign tick = (cnt_q == CW'(CYC - 1));

            always_comb begin
                cnt_d = cnt_q + CW'(1);
                if (clr || tick) cnt_d = '0;
            end

            always_ff @(posedge clk) begin
                if (!rst_n) cnt_q <= '0;
                else        cnt_q <= cnt_d;
            end

            // a quantum boundary is never two cycles in a row
            assert_tick_spaced_R5: assert property (@(posedge clk) disable iff (!rst_n)
                tick |=> !tick);
        end else begin : g_pass
            assign tick = 1'b1;
        end
    endgenerate

endmodule

// File: rtl/rxpause_level_cmp.sv
module rxpause_level_cmp #(
    parameter int LVL_W = 18,
    parameter int WM_W  = 15
) (
    input  logic [LVL_W-1:0] fill_bytes,
    input  logic [WM_W-1:0]  hi_mark,
    input  logic [WM_W-1:0]  lo_mark,
    input  logic             tx_pause_en,
    output logic             gen_allowed,
    output logic             at_high,
    output logic             below_low
);
    localparam int CMP_W = (LVL_W > WM_W + 3) ? LVL_W : WM_W + 3;

    logic [CMP_W-1:0] lvl_ext, hi_bytes, lo_bytes;

    always_comb begin
        lvl_ext     = CMP_W'(fill_bytes);
        hi_bytes    = CMP_W'(hi_mark) << 3;
        lo_bytes    = CMP_W'(lo_mark) << 3;
        gen_allowed = tx_pause_en && (hi_mark != '0);
        at_high     = lvl_ext >= hi_bytes;
        below_low   = lvl_ext < lo_bytes;
    end

endmodule

// File: rtl/rxpause_halt_timer.sv
module rxpause_halt_timer #(
    parameter int QT_W        = 16,
    parameter int QUANTUM_CYC = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            honor_en,
    input  logic            frame_seen,
    input  logic [QT_W-1:0] frame_quanta,
    output logic            halt
);
    typedef struct packed {
        logic [QT_W-1:0] remain;
    } halt_st_t;

    halt_st_t st_d, st_q;
    logic     q_tick;
    logic     load;

    assign load = honor_en && frame_seen;

    rxpause_quanta_tick #(.CYC(QUANTUM_CYC)) u_tick (
        .clk  (clk),
        .rst_n(rst_n),
        .clr  (load),
        .tick (q_tick)
    );

    always_comb begin
        st_d = st_q;
        if (!honor_en)
            st_d.remain = '0;
        else if (load)
            st_d.remain = frame_quanta;
        else if (q_tick && st_q.remain != '0)
            st_d.remain = st_q.remain - QT_W'(1);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign halt = (st_q.remain != '0);

    assert_ignore_when_off_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !honor_en |=> !halt);

    assert_zero_frame_clears_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (load && frame_quanta == '0) |=> !halt);

endmodule

// File: rtl/rxpause_wm_ctrl.sv
module rxpause_wm_ctrl
    import rxpause_pkg::*;
#(
    parameter int LVL_W       = 18,
    parameter int WM_W        = 15,
    parameter int QT_W        = 16,
    parameter int QUANTUM_CYC = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [LVL_W-1:0] fill_bytes,
    input  logic [WM_W-1:0]  hi_mark,
    input  logic [WM_W-1:0]  lo_mark,
    input  logic [QT_W-1:0]  pause_quanta_cfg,
    input  logic             tx_pause_en,
    input  logic             rx_honor_en,
    input  logic             rx_pause_seen,
    input  logic [QT_W-1:0]  rx_pause_time,
    output logic             pause_req,
    output logic [QT_W-1:0]  pause_req_quanta,
    output logic             tx_halt
);
    localparam logic [QT_W-1:0] ELAPSED_MAX = '1;

    typedef struct packed {
        fc_state_e       st;
        logic            req_v;
        logic [QT_W-1:0] req_qt;
        logic [QT_W-1:0] elapsed;
    } ctrl_t;

    ctrl_t ctl_d, ctl_q;

    logic            gen_allowed, at_high, below_low;
    logic            q_tick, restart;
    logic [QT_W-1:0] refresh_thr;

    rxpause_level_cmp #(.LVL_W(LVL_W), .WM_W(WM_W)) u_cmp (
        .fill_bytes (fill_bytes),
        .hi_mark    (hi_mark),
        .lo_mark    (lo_mark),
        .tx_pause_en(tx_pause_en),
        .gen_allowed(gen_allowed),
        .at_high    (at_high),
        .below_low  (below_low)
    );

    rxpause_quanta_tick #(.CYC(QUANTUM_CYC)) u_refresh_tick (
        .clk  (clk),
        .rst_n(rst_n),
        .clr  (restart),
        .tick (q_tick)
    );

    rxpause_halt_timer #(.QT_W(QT_W), .QUANTUM_CYC(QUANTUM_CYC)) u_halt (
        .clk         (clk),
        .rst_n       (rst_n),
        .honor_en    (rx_honor_en),
        .frame_seen  (rx_pause_seen),
        .frame_quanta(rx_pause_time),
        .halt        (tx_halt)
    );

    always_comb begin
        refresh_thr = pause_quanta_cfg >> 1;
        if (refresh_thr == '0) refresh_thr = QT_W'(1);
    end

    always_comb begin
        ctl_d        = ctl_q;
        ctl_d.req_v  = 1'b0;
        ctl_d.req_qt = '0;
        restart      = 1'b0;

        if (q_tick && ctl_q.elapsed != ELAPSED_MAX)
            ctl_d.elapsed = ctl_q.elapsed + QT_W'(1);

        unique case (ctl_q.st)
            FC_IDLE: begin
                if (gen_allowed && at_high) begin
                    ctl_d.st     = FC_PAUSED;
                    ctl_d.req_v  = 1'b1;
                    ctl_d.req_qt = pause_quanta_cfg;
                    restart      = 1'b1;
                end
            end
            FC_PAUSED: begin
                if (!gen_allowed || below_low) begin
                    // resume wins over a refresh due in the same cycle
                    ctl_d.st     = FC_IDLE;
                    ctl_d.req_v  = 1'b1;
                    ctl_d.req_qt = '0;
                end else if (ctl_q.elapsed >= refresh_thr) begin
                    ctl_d.req_v  = 1'b1;
                    ctl_d.req_qt = pause_quanta_cfg;
                    restart      = 1'b1;
                end
            end
            default: ctl_d.st = FC_IDLE;
        endcase

        if (restart) ctl_d.elapsed = '0;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctl_q.st      <= FC_IDLE;
            ctl_q.req_v   <= 1'b0;
            ctl_q.req_qt  <= '0;
            ctl_q.elapsed <= '0;
        end else begin
            ctl_q <= ctl_d;
        end
    end

    assign pause_req        = ctl_q.req_v;
    assign pause_req_quanta = ctl_q.req_qt;

    assert_pause_quanta_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (pause_req && ctl_q.st == FC_PAUSED) |-> (pause_req_quanta == $past(pause_quanta_cfg)));

    assert_resume_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (pause_req && ctl_q.st == FC_IDLE) |-> (pause_req_quanta == '0));

    assert_hwm_zero_quiet_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_q.st == FC_IDLE && hi_mark == '0) |=> !pause_req);

    assert_disable_resumes_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_q.st == FC_PAUSED && !tx_pause_en) |=> (pause_req && ctl_q.st == FC_IDLE));

endmodule

// File: tb/rxpause_wm_ctrl_bench.sv
module rxpause_wm_ctrl_bench;
    localparam int LVL_W = 18;
    localparam int WM_W  = 15;
    localparam int QT_W  = 16;
    localparam int QC    = 8;
    localparam int NVEC  = 12;

    // {level, expected pulse, expected quanta}; hi=16 (128 B), lo=8 (64 B), pause=0x40
    localparam logic [LVL_W+QT_W:0] TBL [NVEC] = '{
        {18'd0,   1'b0, 16'h0000},
        {18'd127, 1'b0, 16'h0000},
        {18'd128, 1'b1, 16'h0040},
        {18'd128, 1'b0, 16'h0000},
        {18'd300, 1'b0, 16'h0000},
        {18'd64,  1'b0, 16'h0000},
        {18'd63,  1'b1, 16'h0000},
        {18'd63,  1'b0, 16'h0000},
        {18'd100, 1'b0, 16'h0000},
        {18'd129, 1'b1, 16'h0040},
        {18'd0,   1'b1, 16'h0000},
        {18'd0,   1'b0, 16'h0000}
    };

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic [LVL_W-1:0] fill_bytes = '0;
    logic [WM_W-1:0]  hi_mark = '0;
    logic [WM_W-1:0]  lo_mark = '0;
    logic [QT_W-1:0]  pause_quanta_cfg = '0;
    logic             tx_pause_en = 1'b0;
    logic             rx_honor_en = 1'b0;
    logic             rx_pause_seen = 1'b0;
    logic [QT_W-1:0]  rx_pause_time = '0;
    logic             pause_req;
    logic [QT_W-1:0]  pause_req_quanta;
    logic             tx_halt;

    int checks = 0;
    int errors = 0;

    always #2 clk = ~clk;

    rxpause_wm_ctrl #(.LVL_W(LVL_W), .WM_W(WM_W), .QT_W(QT_W), .QUANTUM_CYC(QC)) u_rxpause_wm_ctrl (
        .clk             (clk),
        .rst_n           (rst_n),
        .fill_bytes      (fill_bytes),
        .hi_mark         (hi_mark),
        .lo_mark         (lo_mark),
        .pause_quanta_cfg(pause_quanta_cfg),
        .tx_pause_en     (tx_pause_en),
        .rx_honor_en     (rx_honor_en),
        .rx_pause_seen   (rx_pause_seen),
        .rx_pause_time   (rx_pause_time),
        .pause_req       (pause_req),
        .pause_req_quanta(pause_req_quanta),
        .tx_halt         (tx_halt)
    );

    task automatic check(input string req, input longint act, input longint exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic step;
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic watch_quiet(input string req, input int n);
        int seen = 0;
        for (int i = 0; i < n; i++) begin
            step();
            if (pause_req) seen++;
        end
        check(req, seen, 0);
    endtask

    task automatic measure_halt(input logic [QT_W-1:0] qt, output int cyc);
        rx_pause_time = qt;
        rx_pause_seen = 1'b1;
        step();
        rx_pause_seen = 1'b0;
        cyc = 0;
        while (tx_halt && cyc < 5000) begin
            cyc++;
            @(negedge clk);
        end
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin : main
        int n;
        repeat (3) @(negedge clk);
        // R1: reset state
        check("R1 pause_req", pause_req, 0);
        check("R1 tx_halt", tx_halt, 0);
        rst_n = 1'b1;
        step();
        check("R1 idle after release", pause_req, 0);

        // R2 R3 R6: table of levels
        hi_mark = 15'd16;
        lo_mark = 15'd8;
        pause_quanta_cfg = 16'h0040;
        tx_pause_en = 1'b1;
        for (int i = 0; i < NVEC; i++) begin
            fill_bytes = TBL[i][LVL_W+QT_W:QT_W+1];
            step();
            check($sformatf("R2/R3/R6 vec%0d pulse", i), pause_req, TBL[i][QT_W]);
            if (TBL[i][QT_W])
                check($sformatf("R3/R6 vec%0d quanta", i), pause_req_quanta, TBL[i][QT_W-1:0]);
        end

        // R4: zero high mark silences generation
        hi_mark = '0;
        fill_bytes = 18'd4000;
        watch_quiet("R4 hi_mark zero", 20);
        // R4: enable low silences generation
        hi_mark = 15'd16;
        tx_pause_en = 1'b0;
        watch_quiet("R4 tx_pause_en low", 20);

        // R5: refresh spacing, pause time 10 -> 5 quanta -> 5*QC+1 cycles
        fill_bytes = '0;
        tx_pause_en = 1'b1;
        pause_quanta_cfg = 16'd10;
        step();
        fill_bytes = 18'd200;
        step();
        check("R5 initial pulse", pause_req, 1);
        n = 0;
        do begin
            @(negedge clk);
            n++;
        end while (!pause_req && n < 1000);
        check("R5 refresh spacing", n, 5 * QC + 1);
        check("R5 refresh quanta", pause_req_quanta, 10);
        n = 0;
        do begin
            @(negedge clk);
            n++;
        end while (!pause_req && n < 1000);
        check("R5 second refresh spacing", n, 5 * QC + 1);

        // R7: disabling while paused sends a resume
        step();
        tx_pause_en = 1'b0;
        step();
        check("R7 resume pulse", pause_req, 1);
        check("R7 resume quanta", pause_req_quanta, 0);
        step();
        check("R7 single resume", pause_req, 0);
        // R7: zeroing the high mark while paused
        tx_pause_en = 1'b1;
        step();
        check("R7 re-pause", pause_req, 1);
        hi_mark = '0;
        step();
        check("R7 hi_mark zero resume", pause_req, 1);
        check("R7 hi_mark zero quanta", pause_req_quanta, 0);
        fill_bytes = '0;
        hi_mark = 15'd16;

        // R8: received pause honoured
        rx_honor_en = 1'b1;
        measure_halt(16'd3, n);
        check("R8 halt length", n, 3 * QC);
        rx_pause_time = 16'd50;
        rx_pause_seen = 1'b1;
        step();
        rx_pause_seen = 1'b0;
        repeat (5) step();
        check("R8 halt running", tx_halt, 1);
        rx_pause_time = 16'd0;
        rx_pause_seen = 1'b1;
        step();
        rx_pause_seen = 1'b0;
        check("R8 zero frame clears", tx_halt, 0);

        // R9: honour disabled
        rx_pause_time = 16'd50;
        rx_pause_seen = 1'b1;
        step();
        rx_pause_seen = 1'b0;
        check("R9 precondition halt", tx_halt, 1);
        rx_honor_en = 1'b0;
        step();
        check("R9 drop clears halt", tx_halt, 0);
        rx_pause_seen = 1'b1;
        step();
        rx_pause_seen = 1'b0;
        check("R9 frame ignored", tx_halt, 0);
        step();
        check("R9 still low", tx_halt, 0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule